// File: doc/BRIEF.md
# Snooping Cache Coherence State Controller

This block keeps a three-state coherence record (modified, exclusive, invalid) for every line of a small direct-mapped data-cache tag array, and ties that record to a shared address bus. Local load and store requests look up the tag array. A read miss allocates the line as exclusive, and a store leaves the line modified. When this agent owns the address bus, each local access it accepts starts a bus transaction. The block drives the sharing qualifier for that transaction from the page's coherence attribute bit.

When another agent owns the bus, the block watches for transaction starts. It looks up only those starts whose sharing qualifier arrives in the same clock. A snoop that hits a modified line gets an address retry and opens a write-back of that line. The line stays modified until the write-back completion input arrives, and then becomes invalid. A snoop that hits an exclusive line invalidates it silently. A local access that carries the direct-store attribute is reported as a bus error and is not performed. Data storage, the data-bus handshake and address translation belong to neighbouring blocks.

Top module: `mei_snoop_ctrl`

## Requirements
- R1: After synchronous reset every line is invalid, and `retry_out`, `bus_err`, `bus_ts_out`, `bus_gbl_out`, `bus_gbl_oe`, `wb_req` and `lcl_ack` are low.
- R2: Line states are encoded invalid=2'b00, exclusive=2'b01, modified=2'b10. An accepted local read reports `lcl_hit` and the line's prior state on `lcl_state` one cycle later. A read miss fills the line as exclusive, and a read hit leaves the state unchanged.
- R3: An accepted local write sets the addressed line to modified, whether it hit or missed.
- R4: When `is_master` is high, an accepted local access drives `bus_ts_out` high for one cycle on the next cycle, with `bus_addr_out` equal to the access address and `bus_gbl_out` equal to `lcl_coh`. `bus_gbl_oe` follows `is_master` one cycle later, and `bus_gbl_out` is low whenever this agent is not starting a transaction.
- R5: A bus transaction is snooped only when `bus_ts_in` and `bus_gbl_in` are high in the same cycle and `is_master` is low. Any other combination leaves all line states and `retry_out` unchanged.
- R6: A qualified snoop that hits a modified line raises `retry_out` for one cycle on the next cycle and raises `wb_req` with the line's address on `wb_addr`. The line becomes invalid in the cycle after `wb_done` is seen.
- R7: A qualified snoop that hits an exclusive line makes it invalid with no retry. A snoop that misses on tag, or lands on an invalid line, changes nothing.
- R8: A qualified snoop has priority over a local request in the same cycle. That local request is not accepted (`lcl_ack` stays low) and changes no state.
- R9: A local request with `lcl_dstore` high raises `bus_err` for one cycle on the next cycle. It is not acknowledged, changes no line state and starts no bus transaction.
- R10: While a write-back is pending, local requests are not accepted. A `wb_done` with no pending write-back has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | This agent owns the address bus |
| lcl_req | input | 1 | Local access request |
| lcl_we | input | 1 | Local access is a store |
| lcl_addr | input | AW | Local access address |
| lcl_coh | input | 1 | Page coherence-required attribute |
| lcl_dstore | input | 1 | Access carries the direct-store attribute |
| lcl_ack | output | 1 | Local access accepted (registered) |
| lcl_hit | output | 1 | Accepted access hit a valid line |
| lcl_state | output | 2 | Prior state of the accessed line |
| bus_ts_in | input | 1 | Observed transaction start |
| bus_gbl_in | input | 1 | Observed sharing qualifier |
| bus_addr_in | input | AW | Observed transaction address |
| bus_ts_out | output | 1 | Transaction start driven as master |
| bus_gbl_out | output | 1 | Sharing qualifier driven as master |
| bus_gbl_oe | output | 1 | Output enable for the sharing qualifier |
| bus_addr_out | output | AW | Address of the started transaction |
| retry_out | output | 1 | Address retry request |
| bus_err | output | 1 | Direct-store bus error flag |
| wb_req | output | 1 | Write-back pending |
| wb_addr | output | AW | Line address of the pending write-back |
| wb_done | input | 1 | Write-back finished |

## Verification
Every result of this block is registered. Retry, error, acknowledge, hit/state report and bus-start outputs appear exactly one clock after the input cycle that caused them. A line-state change made in cycle N shows up on the `lcl_state` report of a read issued in cycle N+1 or later. The bench drives each stimulus on a falling edge, releases it on the next falling edge, and samples there, one rising edge after the stimulus. Each line state is then probed through a follow-up local read and compared against the value predicted by the requirements, including the cycle after a one-cycle pulse to confirm that it dropped.

// File: rtl/mei_pkg.sv
package mei_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_EXC = 2'b01,
        ST_MOD = 2'b10
    } mei_state_e;

    typedef enum logic [1:0] {
        SN_NONE  = 2'b00,
        SN_INVAL = 2'b01,
        SN_RETRY = 2'b10
    } snoop_act_e;

    // Local access: store makes modified, read miss fills exclusive.
    function automatic mei_state_e local_next(input logic we, input mei_state_e cur, input logic hit);
        if (we)
            return ST_MOD;
        else if (!hit)
            return ST_EXC;
        else
            return cur;
    endfunction

    function automatic snoop_act_e snoop_decide(input logic qual, input logic hit, input mei_state_e cur);
        if (!qual || !hit)
            return SN_NONE;
        else if (cur == ST_MOD)
            return SN_RETRY;
        else if (cur == ST_EXC)
            return SN_INVAL;
        else
            return SN_NONE;
    endfunction

endpackage

// File: rtl/mei_line_store.sv
module mei_line_store
    import mei_pkg::*;
#(
    parameter int LINES = 16,
    parameter int TAGW  = 23,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_a_en,
    input  logic [IDXW-1:0]  inv_a_idx,
    input  logic             inv_b_en,
    input  logic [IDXW-1:0]  inv_b_idx,
    input  logic             fill_en,
    input  logic [IDXW-1:0]  fill_idx,
    input  logic [TAGW-1:0]  fill_tag,
    input  mei_state_e       fill_state,
    input  logic [IDXW-1:0]  rd_a_idx,
    output mei_state_e       rd_a_state,
    output logic [TAGW-1:0]  rd_a_tag,
    input  logic [IDXW-1:0]  rd_b_idx,
    output mei_state_e       rd_b_state,
    output logic [TAGW-1:0]  rd_b_tag
);

    logic [LINES-1:0][TAGW-1:0] tag_flat;
    logic [LINES-1:0][1:0]      st_flat;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TAGW-1:0] tag_r;
        mei_state_e      st_r;
        logic            kill;
        logic            load;

        assign kill = (inv_a_en && inv_a_idx == IDXW'(g)) ||
                      (inv_b_en && inv_b_idx == IDXW'(g));
        assign load = fill_en && fill_idx == IDXW'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r  <= ST_INV;
                tag_r <= '0;
            end else if (kill) begin
                st_r <= ST_INV;
            end else if (load) begin
                st_r  <= fill_state;
                tag_r <= fill_tag;
            end
        end

        assign tag_flat[g] = tag_r;
        assign st_flat[g]  = st_r;
    end

    assign rd_a_state = mei_state_e'(st_flat[rd_a_idx]);
    assign rd_a_tag   = tag_flat[rd_a_idx];
    assign rd_b_state = mei_state_e'(st_flat[rd_b_idx]);
    assign rd_b_tag   = tag_flat[rd_b_idx];

endmodule

// File: rtl/mei_snoop_eval.sv
module mei_snoop_eval
    import mei_pkg::*;
#(
    parameter int TAGW = 23
) (
    input  logic            is_master,
    input  logic            ts,
    input  logic            gbl,
    input  logic [TAGW-1:0] snp_tag,
    input  logic [TAGW-1:0] line_tag,
    input  mei_state_e      line_state,
    output logic            qual,
    output logic            hit,
    output snoop_act_e      act
);

    always_comb begin
        qual = ts && gbl && !is_master;
        hit  = (line_state != ST_INV) && (line_tag == snp_tag);
        act  = snoop_decide(qual, hit, line_state);
    end

endmodule

// File: rtl/mei_snoop_ctrl.sv
module mei_snoop_ctrl
    import mei_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LINES = 16,
    parameter int OFFW  = 5,
    localparam int IDXW = $clog2(LINES),
    localparam int TAGW = AW - IDXW - OFFW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          is_master,
    input  logic          lcl_req,
    input  logic          lcl_we,
    input  logic [AW-1:0] lcl_addr,
    input  logic          lcl_coh,
    input  logic          lcl_dstore,
    output logic          lcl_ack,
    output logic          lcl_hit,
    output logic [1:0]    lcl_state,
    input  logic          bus_ts_in,
    input  logic          bus_gbl_in,
    input  logic [AW-1:0] bus_addr_in,
    output logic          bus_ts_out,
    output logic          bus_gbl_out,
    output logic          bus_gbl_oe,
    output logic [AW-1:0] bus_addr_out,
    output logic          retry_out,
    output logic          bus_err,
    output logic          wb_req,
    output logic [AW-1:0] wb_addr,
    input  logic          wb_done
);

    logic [IDXW-1:0] snp_idx, lcl_idx, wb_idx;
    logic [TAGW-1:0] snp_tag, lcl_tag;
    assign snp_idx = bus_addr_in[OFFW +: IDXW];
    assign snp_tag = bus_addr_in[AW-1 -: TAGW];
    assign lcl_idx = lcl_addr[OFFW +: IDXW];
    assign lcl_tag = lcl_addr[AW-1 -: TAGW];

    mei_state_e      snp_line_st, lcl_line_st;
    logic [TAGW-1:0] snp_line_tag, lcl_line_tag;

    logic       snp_qual, snp_hit;
    snoop_act_e snp_act;

    logic       wb_pend_q;
    logic [AW-1:0] wb_addr_q;
    assign wb_idx = wb_addr_q[OFFW +: IDXW];

    // Local path gating: snoop wins, pending write-back stalls.
    logic lcl_err, lcl_go, lcl_hit_c, wb_finish, wb_open;
    mei_state_e lcl_new_st;

    always_comb begin
        lcl_err    = lcl_req && lcl_dstore && !snp_qual;
        lcl_go     = lcl_req && !lcl_dstore && !snp_qual && !wb_pend_q;
        lcl_hit_c  = (lcl_line_st != ST_INV) && (lcl_line_tag == lcl_tag);
        lcl_new_st = local_next(lcl_we, lcl_line_st, lcl_hit_c);
        wb_finish  = wb_done && wb_pend_q;
        wb_open    = (snp_act == SN_RETRY) && !wb_pend_q;
    end

    mei_line_store #(.LINES(LINES), .TAGW(TAGW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .inv_a_en   (snp_act == SN_INVAL),
        .inv_a_idx  (snp_idx),
        .inv_b_en   (wb_finish),
        .inv_b_idx  (wb_idx),
        .fill_en    (lcl_go),
        .fill_idx   (lcl_idx),
        .fill_tag   (lcl_tag),
        .fill_state (lcl_new_st),
        .rd_a_idx   (snp_idx),
        .rd_a_state (snp_line_st),
        .rd_a_tag   (snp_line_tag),
        .rd_b_idx   (lcl_idx),
        .rd_b_state (lcl_line_st),
        .rd_b_tag   (lcl_line_tag)
    );

    mei_snoop_eval #(.TAGW(TAGW)) u_eval (
        .is_master  (is_master),
        .ts         (bus_ts_in),
        .gbl        (bus_gbl_in),
        .snp_tag    (snp_tag),
        .line_tag   (snp_line_tag),
        .line_state (snp_line_st),
        .qual       (snp_qual),
        .hit        (snp_hit),
        .act        (snp_act)
    );

    // Snoop response and write-back tracking.
    always_ff @(posedge clk) begin
        if (rst) begin
            retry_out <= 1'b0;
            wb_pend_q <= 1'b0;
            wb_addr_q <= '0;
        end else begin
            retry_out <= (snp_act == SN_RETRY);
            if (wb_open) begin
                wb_pend_q <= 1'b1;
                wb_addr_q <= {snp_tag, snp_idx, {OFFW{1'b0}}};
            end else if (wb_finish) begin
                wb_pend_q <= 1'b0;
            end
        end
    end

    // Local result and bus start.
    always_ff @(posedge clk) begin
        if (rst) begin
            lcl_ack      <= 1'b0;
            lcl_hit      <= 1'b0;
            lcl_state    <= ST_INV;
            bus_err      <= 1'b0;
            bus_ts_out   <= 1'b0;
            bus_gbl_out  <= 1'b0;
            bus_gbl_oe   <= 1'b0;
            bus_addr_out <= '0;
        end else begin
            lcl_ack     <= lcl_go;
            lcl_hit     <= lcl_go && lcl_hit_c;
            lcl_state   <= lcl_go ? (lcl_hit_c ? lcl_line_st : ST_INV) : ST_INV;
            bus_err     <= lcl_err;
            bus_gbl_oe  <= is_master;
            bus_ts_out  <= lcl_go && is_master;
            bus_gbl_out <= lcl_go && is_master && lcl_coh;
            if (lcl_go && is_master)
                bus_addr_out <= lcl_addr;
        end
    end

    assign wb_req  = wb_pend_q;
    assign wb_addr = wb_addr_q;

    logic unused_ok;
    assign unused_ok = snp_hit;

endmodule

// File: rtl/mei_ctrl_chk.sv
module mei_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic is_master,
    input logic lcl_req,
    input logic lcl_dstore,
    input logic lcl_ack,
    input logic bus_ts_in,
    input logic bus_gbl_in,
    input logic bus_ts_out,
    input logic bus_gbl_out,
    input logic bus_gbl_oe,
    input logic retry_out,
    input logic bus_err,
    input logic wb_req,
    input logic wb_done
);

    assert_gbl_needs_ts_R4: assert property (@(posedge clk) disable iff (rst)
        bus_gbl_out |-> bus_ts_out);

    assert_gbl_oe_follows_R4: assert property (@(posedge clk) disable iff (rst)
        bus_gbl_oe == $past(is_master));

    assert_retry_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        retry_out |-> $past(bus_ts_in && bus_gbl_in && !is_master));

    assert_wb_held_R6: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_done) |=> wb_req);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($past(lcl_req && lcl_dstore) && !lcl_ack && !bus_ts_out));

    assert_ack_cause_R8: assert property (@(posedge clk) disable iff (rst)
        lcl_ack |-> $past(lcl_req && !lcl_dstore && !(bus_ts_in && bus_gbl_in && !is_master)));

    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        wb_req |=> !lcl_ack);

endmodule

bind mei_snoop_ctrl mei_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .is_master  (is_master),
    .lcl_req    (lcl_req),
    .lcl_dstore (lcl_dstore),
    .lcl_ack    (lcl_ack),
    .bus_ts_in  (bus_ts_in),
    .bus_gbl_in (bus_gbl_in),
    .bus_ts_out (bus_ts_out),
    .bus_gbl_out(bus_gbl_out),
    .bus_gbl_oe (bus_gbl_oe),
    .retry_out  (retry_out),
    .bus_err    (bus_err),
    .wb_req     (wb_req),
    .wb_done    (wb_done)
);

// File: tb/sim_mei_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mei_snoop_ctrl;

    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst;
    logic is_master, lcl_req, lcl_we, lcl_coh, lcl_dstore;
    logic [AW-1:0] lcl_addr, bus_addr_in;
    logic bus_ts_in, bus_gbl_in, wb_done;
    logic lcl_ack, lcl_hit, bus_ts_out, bus_gbl_out, bus_gbl_oe, retry_out, bus_err, wb_req;
    logic [1:0] lcl_state;
    logic [AW-1:0] bus_addr_out, wb_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mei_snoop_ctrl u0 (
        .clk(clk), .rst(rst), .is_master(is_master),
        .lcl_req(lcl_req), .lcl_we(lcl_we), .lcl_addr(lcl_addr), .lcl_coh(lcl_coh),
        .lcl_dstore(lcl_dstore), .lcl_ack(lcl_ack), .lcl_hit(lcl_hit), .lcl_state(lcl_state),
        .bus_ts_in(bus_ts_in), .bus_gbl_in(bus_gbl_in), .bus_addr_in(bus_addr_in),
        .bus_ts_out(bus_ts_out), .bus_gbl_out(bus_gbl_out), .bus_gbl_oe(bus_gbl_oe),
        .bus_addr_out(bus_addr_out), .retry_out(retry_out), .bus_err(bus_err),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_done(wb_done)
    );

    function automatic logic [AW-1:0] mk(input logic [22:0] tag, input logic [3:0] idx);
        return {tag, idx, 5'b0};
    endfunction

    task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        lcl_req = 0; lcl_we = 0; lcl_dstore = 0; lcl_coh = 0;
        bus_ts_in = 0; bus_gbl_in = 0; wb_done = 0;
    endtask

    // Drive one local access, step one edge, leave outputs to sample.
    task automatic access(input logic we, input logic [AW-1:0] a, input logic coh, input logic ds);
        lcl_req = 1; lcl_we = we; lcl_addr = a; lcl_coh = coh; lcl_dstore = ds;
        @(negedge clk);
        idle();
    endtask

    task automatic snoop(input logic ts, input logic gbl, input logic [AW-1:0] a);
        bus_ts_in = ts; bus_gbl_in = gbl; bus_addr_in = a;
        @(negedge clk);
        idle();
    endtask

    task automatic probe(input string req, input logic [AW-1:0] a, input logic exp_hit, input logic [1:0] exp_st);
        access(0, a, 0, 0);
        chk(req, "probe ack", 32'(lcl_ack), 1);
        chk(req, "probe hit", 32'(lcl_hit), 32'(exp_hit));
        chk(req, "probe state", 32'(lcl_state), 32'(exp_st));
    endtask

    task automatic t_reset();
        chk("R1", "retry", 32'(retry_out), 0);
        chk("R1", "err", 32'(bus_err), 0);
        chk("R1", "ts_out", 32'(bus_ts_out), 0);
        chk("R1", "gbl_out", 32'(bus_gbl_out), 0);
        chk("R1", "gbl_oe", 32'(bus_gbl_oe), 0);
        chk("R1", "wb_req", 32'(wb_req), 0);
        chk("R1", "ack", 32'(lcl_ack), 0);
        for (int i = 0; i < 16; i += 5) probe("R1", mk(23'h1234, 4'(i)), 0, 2'b00);
    endtask

    task automatic t_fill();
        probe("R2", mk(23'h0aa, 4'd3), 0, 2'b00);
        probe("R2", mk(23'h0aa, 4'd3), 1, 2'b01);
        probe("R2", mk(23'h0aa, 4'd3), 1, 2'b01);
        access(1, mk(23'h0aa, 4'd3), 0, 0);
        chk("R3", "write ack", 32'(lcl_ack), 1);
        chk("R3", "write prior", 32'(lcl_state), 32'(2'b01));
        probe("R3", mk(23'h0aa, 4'd3), 1, 2'b10);
        access(1, mk(23'h0bb, 4'd4), 0, 0);
        probe("R3", mk(23'h0bb, 4'd4), 1, 2'b10);
    endtask

    task automatic t_master();
        is_master = 1;
        access(0, mk(23'h777, 4'd6), 1, 0);
        chk("R4", "ts_out", 32'(bus_ts_out), 1);
        chk("R4", "gbl_out", 32'(bus_gbl_out), 1);
        chk("R4", "gbl_oe", 32'(bus_gbl_oe), 1);
        chk("R4", "addr_out", bus_addr_out, mk(23'h777, 4'd6));
        @(negedge clk);
        chk("R4", "ts_out drop", 32'(bus_ts_out), 0);
        chk("R4", "gbl idle", 32'(bus_gbl_out), 0);
        access(0, mk(23'h778, 4'd8), 0, 0);
        chk("R4", "ts_out2", 32'(bus_ts_out), 1);
        chk("R4", "gbl follows attr", 32'(bus_gbl_out), 0);
        // master ignores observed starts
        access(1, mk(23'h050, 4'd12), 0, 0);
        snoop(1, 1, mk(23'h050, 4'd12));
        chk("R5", "no retry as master", 32'(retry_out), 0);
        is_master = 0;
        @(negedge clk);
        chk("R4", "gbl_oe off", 32'(bus_gbl_oe), 0);
        chk("R4", "gbl_out off", 32'(bus_gbl_out), 0);
        probe("R5", mk(23'h050, 4'd12), 1, 2'b10);
    endtask

    task automatic t_snoop_excl();
        probe("R7", mk(23'h155, 4'd5), 0, 2'b00);
        snoop(1, 0, mk(23'h155, 4'd5));
        chk("R5", "ts only retry", 32'(retry_out), 0);
        snoop(0, 1, mk(23'h155, 4'd5));
        probe("R5", mk(23'h155, 4'd5), 1, 2'b01);
        snoop(1, 1, mk(23'h156, 4'd5));
        chk("R7", "tag miss retry", 32'(retry_out), 0);
        probe("R7", mk(23'h155, 4'd5), 1, 2'b01);
        snoop(1, 1, mk(23'h155, 4'd5));
        chk("R7", "excl retry", 32'(retry_out), 0);
        probe("R7", mk(23'h155, 4'd5), 0, 2'b00);
        snoop(1, 1, mk(23'h3ff, 4'd13));
        chk("R7", "invalid line retry", 32'(retry_out), 0);
    endtask

    task automatic t_snoop_mod();
        access(1, mk(23'h2a2, 4'd7), 0, 0);
        snoop(1, 1, mk(23'h2a2, 4'd7));
        chk("R6", "retry", 32'(retry_out), 1);
        chk("R6", "wb_req", 32'(wb_req), 1);
        chk("R6", "wb_addr", wb_addr, mk(23'h2a2, 4'd7));
        @(negedge clk);
        chk("R6", "retry one cycle", 32'(retry_out), 0);
        access(0, mk(23'h2a2, 4'd7), 0, 0);
        chk("R10", "stall ack", 32'(lcl_ack), 0);
        chk("R6", "wb held", 32'(wb_req), 1);
        wb_done = 1;
        @(negedge clk);
        wb_done = 0;
        chk("R6", "wb cleared", 32'(wb_req), 0);
        probe("R6", mk(23'h2a2, 4'd7), 0, 2'b00);
        wb_done = 1;
        @(negedge clk);
        wb_done = 0;
        chk("R10", "stray done", 32'(wb_req), 0);
        probe("R10", mk(23'h2a2, 4'd7), 1, 2'b01);
    endtask

    task automatic t_priority();
        probe("R8", mk(23'h099, 4'd9), 0, 2'b00);
        lcl_req = 1; lcl_we = 1; lcl_addr = mk(23'h099, 4'd9);
        bus_ts_in = 1; bus_gbl_in = 1; bus_addr_in = mk(23'h011, 4'd2);
        @(negedge clk);
        idle();
        chk("R8", "ack blocked", 32'(lcl_ack), 0);
        probe("R8", mk(23'h099, 4'd9), 1, 2'b01);
    endtask

    task automatic t_dstore();
        is_master = 1;
        access(0, mk(23'h0de, 4'd11), 1, 1);
        chk("R9", "err", 32'(bus_err), 1);
        chk("R9", "ack", 32'(lcl_ack), 0);
        chk("R9", "ts_out", 32'(bus_ts_out), 0);
        @(negedge clk);
        chk("R9", "err one cycle", 32'(bus_err), 0);
        is_master = 0;
        probe("R9", mk(23'h0de, 4'd11), 0, 2'b00);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; is_master = 0; lcl_addr = '0; bus_addr_in = '0;
        idle();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_master();
        t_snoop_excl();
        t_snoop_mod();
        t_priority();
        t_dstore();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule